// File: doc/BRIEF.md
# Strict-Priority Service-Queue Scheduler with Round-Robin Re-entry

This block decides which connection receives the next cell slot. Every connection that holds at least one waiting cell is linked into one of four service queues, chosen by that connection's 2-bit priority. Each service queue is a singly linked list of connection IDs, and the block keeps one head and one tail pointer per level. A single next-pointer table serves all levels, because a connection sits in at most one list at a time.

On each service request, the block picks the highest level that holds any connection. It unlinks the connection at the head of that list and grants it one cell. If that connection still has cells after this grant, it goes back on the tail of the same list. Connections that share a level therefore take turns, and a lower level is served only when every higher level is empty.

The block counts the waiting cells of each connection. It learns of each new cell through a one-cell-per-cycle arrival input. Cell storage itself lies outside the block.

Top module: `svq_sched`

## Requirements
- R1: There are four levels, and priority value 3 is the highest. A grant always goes to the head connection of the highest level that holds any connection. Each connection's priority is its 2-bit field `conn_prio[2*c+1:2*c]`.
- R2: The block samples `serv_req` at a rising edge and presents `gnt_valid` and `gnt_conn` after that same edge. `gnt_valid` is 1 exactly when the request was high and at least one level held a connection. Otherwise `gnt_valid` is 0.
- R3: A connection whose cell count goes from zero to non-zero is appended at the tail of its level's list. Within a level, newcomers are served in the order they arrived.
- R4: A served connection that still has cells is appended at the tail of its own level's list. Connections on the same level therefore rotate, one cell each.
- R5: A served connection whose last cell was granted leaves its list. It is not granted again until a new cell arrives for it.
- R6: A cell that arrives in the same cycle as a grant to the same connection counts toward that connection. The connection then re-enters even if the grant took its last earlier cell.
- R7: A connection receives exactly one grant for each cell that arrived for it.
- R8: Suppose a re-entry and a newcomer append target the same level in one cycle. The re-entering connection is linked first, and the newcomer is linked behind it.
- R9: After reset all lists are empty, no connection holds cells, and `gnt_valid` is 0.
- R10: A connection is never linked twice. An arrival for a connection that is already linked only raises its cell count and leaves the service order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conn_prio | input | NUM_CONN*2 | Static 2-bit priority per connection, connection c in bits [2c+1:2c] |
| arr_valid | input | 1 | One cell arrives this cycle |
| arr_conn | input | $clog2(NUM_CONN) | Connection of the arriving cell |
| serv_req | input | 1 | Service opportunity: grant one cell this cycle |
| gnt_valid | output | 1 | Registered: a grant was issued |
| gnt_conn | output | $clog2(NUM_CONN) | Registered: connection granted |

## Verification
Several properties are checked on every cycle:
- The number of linked connections equals the number of connections that hold cells, which guards R10.
- A request with work pending is always answered, and no request means no grant.
- The head that gets served is both linked and holding cells.
- The cell counters never underflow or overflow.

Other behaviour only the bench's scenarios can show: the exact order of strict priority, round-robin rotation and newcomer placement, the same-cycle arrival on the served connection, and the ordering of a re-entry against a newcomer. For these, the bench compares every grant against a queue model built from the requirements.

// File: rtl/svq_pkg.sv
package svq_pkg;
  localparam int PRIO_LEVELS = 4;
  localparam int PRIO_W      = $clog2(PRIO_LEVELS);
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/svq_prio_pick.sv
module svq_prio_pick #(
  parameter int NUM_PRIO = svq_pkg::PRIO_LEVELS,
  localparam int SEL_W   = $clog2(NUM_PRIO)
) (
  input  logic [NUM_PRIO-1:0] level_busy,
  output logic                any_busy,
  output logic [SEL_W-1:0]    top_level
);
  // Highest index wins: scan upward and keep the last busy level.
  always_comb begin
    top_level = '0;
    for (int i = 0; i < NUM_PRIO; i++) begin
      if (level_busy[i]) top_level = SEL_W'(i);
    end
    any_busy = |level_busy;
  end
endmodule

// File: rtl/svq_backlog.sv
module svq_backlog #(
  parameter int NUM_CONN = 16,
  parameter int CNT_W    = 8,
  localparam int ID_W    = $clog2(NUM_CONN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inc_valid,
  input  logic [ID_W-1:0]     inc_id,
  input  logic                dec_valid,
  input  logic [ID_W-1:0]     dec_id,
  output logic [NUM_CONN-1:0] has_cells,
  output logic                remain_nz
);
  logic [CNT_W-1:0] cnt [NUM_CONN];
  logic             same_conn;

  assign same_conn = inc_valid && dec_valid && (inc_id == dec_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CONN; c++) cnt[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CONN; c++) begin
        if (inc_valid && inc_id == ID_W'(c) && !(dec_valid && dec_id == ID_W'(c)))
          cnt[c] <= cnt[c] + CNT_W'(1);
        else if (dec_valid && dec_id == ID_W'(c) && !(inc_valid && inc_id == ID_W'(c)))
          cnt[c] <= cnt[c] - CNT_W'(1);
      end
    end
  end

  for (genvar gi = 0; gi < NUM_CONN; gi++) begin : g_flag
    assign has_cells[gi] = (cnt[gi] != '0);
  end

  // Cells left after this grant: a same-cycle arrival keeps the count up (R6).
  assign remain_nz = same_conn || (cnt[dec_id] > CNT_W'(1));

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> cnt[dec_id] != '0);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (inc_valid && !same_conn) |-> cnt[inc_id] != '1);
endmodule

// File: rtl/svq_sched.sv
module svq_sched #(
  parameter int NUM_CONN = 16,
  parameter int CNT_W    = 8,
  localparam int NUM_PRIO = svq_pkg::PRIO_LEVELS,
  localparam int PRIO_W   = svq_pkg::PRIO_W,
  localparam int ID_W     = $clog2(NUM_CONN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CONN*PRIO_W-1:0] conn_prio,
  input  logic                       arr_valid,
  input  logic [ID_W-1:0]            arr_conn,
  input  logic                       serv_req,
  output logic                       gnt_valid,
  output logic [ID_W-1:0]            gnt_conn
);
  import svq_pkg::*;

  // Per-level list state and the shared link table.
  logic [ID_W-1:0]     head   [NUM_PRIO];
  logic [ID_W-1:0]     tail   [NUM_PRIO];
  logic [NUM_PRIO-1:0] busy;
  logic [ID_W-1:0]     nxt    [NUM_CONN];
  logic [NUM_CONN-1:0] in_q;

  logic [ID_W-1:0]     head_n [NUM_PRIO];
  logic [ID_W-1:0]     tail_n [NUM_PRIO];
  logic [NUM_PRIO-1:0] busy_n;
  logic [ID_W-1:0]     nxt_n  [NUM_CONN];
  logic [NUM_CONN-1:0] in_q_n;

  logic                any_busy;
  prio_t               top_lvl;
  logic                do_srv;
  logic [ID_W-1:0]     srv_id;
  logic                remain_nz;
  logic                reenter;
  logic                newcomer;
  prio_t               new_lvl;
  logic [NUM_CONN-1:0] has_cells;

  svq_prio_pick #(.NUM_PRIO(NUM_PRIO)) pick_i (
    .level_busy (busy),
    .any_busy   (any_busy),
    .top_level  (top_lvl)
  );

  assign do_srv   = serv_req && any_busy;
  assign srv_id   = head[top_lvl];
  assign reenter  = do_srv && remain_nz;
  assign newcomer = arr_valid && !in_q[arr_conn];
  assign new_lvl  = conn_prio[{arr_conn, 1'b0} +: PRIO_W];

  svq_backlog #(.NUM_CONN(NUM_CONN), .CNT_W(CNT_W)) backlog_i (
    .clk       (clk),
    .rst       (rst),
    .inc_valid (arr_valid),
    .inc_id    (arr_conn),
    .dec_valid (do_srv),
    .dec_id    (srv_id),
    .has_cells (has_cells),
    .remain_nz (remain_nz)
  );

  // Pop, then re-entry append, then newcomer append (R8 ordering).
  always_comb begin
    head_n = head;
    tail_n = tail;
    busy_n = busy;
    nxt_n  = nxt;
    in_q_n = in_q;

    if (do_srv) begin
      in_q_n[srv_id] = 1'b0;
      if (head[top_lvl] == tail[top_lvl]) busy_n[top_lvl] = 1'b0;
      else                                head_n[top_lvl] = nxt[srv_id];
    end

    if (reenter) begin
      if (busy_n[top_lvl]) nxt_n[tail_n[top_lvl]] = srv_id;
      else begin
        head_n[top_lvl] = srv_id;
        busy_n[top_lvl] = 1'b1;
      end
      tail_n[top_lvl] = srv_id;
      in_q_n[srv_id]  = 1'b1;
    end

    if (newcomer) begin
      if (busy_n[new_lvl]) nxt_n[tail_n[new_lvl]] = arr_conn;
      else begin
        head_n[new_lvl] = arr_conn;
        busy_n[new_lvl] = 1'b1;
      end
      tail_n[new_lvl]  = arr_conn;
      in_q_n[arr_conn] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    nxt <= nxt_n;
    if (rst) begin
      for (int p = 0; p < NUM_PRIO; p++) begin
        head[p] <= '0;
        tail[p] <= '0;
      end
      busy      <= '0;
      in_q      <= '0;
      gnt_valid <= 1'b0;
      gnt_conn  <= '0;
    end else begin
      head      <= head_n;
      tail      <= tail_n;
      busy      <= busy_n;
      in_q      <= in_q_n;
      gnt_valid <= do_srv;
      gnt_conn  <= srv_id;
    end
  end

  // R10: linked set and backlog set always have the same size.
  a_r10_link_once: assert property (@(posedge clk) disable iff (rst)
    $countones(in_q) == $countones(has_cells));
  a_r2_grant_when_work: assert property (@(posedge clk) disable iff (rst)
    (serv_req && busy != '0) |=> gnt_valid);
  a_r2_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
    !serv_req |=> !gnt_valid);
  a_r1_head_linked: assert property (@(posedge clk) disable iff (rst)
    do_srv |-> in_q[srv_id]);
  a_r5_served_has_cells: assert property (@(posedge clk) disable iff (rst)
    do_srv |-> has_cells[srv_id]);
endmodule

// File: tb/svq_sched_tb_top.sv
module svq_sched_tb_top;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [NC*2-1:0] conn_prio;
  logic          arr_valid;
  logic [3:0]    arr_conn;
  logic          serv_req;
  logic          gnt_valid;
  logic [3:0]    gnt_conn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Model state
  int mq [4][NC];
  int mlen [4];
  int mcnt [NC];
  bit minq [NC];

  always #5 clk = ~clk;

  svq_sched #(.NUM_CONN(NC), .CNT_W(8)) dut_i (
    .clk(clk), .rst(rst), .conn_prio(conn_prio),
    .arr_valid(arr_valid), .arr_conn(arr_conn),
    .serv_req(serv_req), .gnt_valid(gnt_valid), .gnt_conn(gnt_conn)
  );

  function automatic int cp(int c);
    return (c & 3) ^ ((c >> 2) & 3);
  endfunction

  function automatic void mpush(int p, int c);
    mq[p][mlen[p]] = c;
    mlen[p]++;
  endfunction

  function automatic void mpop(int p);
    for (int i = 0; i < NC - 1; i++) mq[p][i] = mq[p][i+1];
    mlen[p]--;
  endfunction

  function automatic int mtotal();
    return mlen[0] + mlen[1] + mlen[2] + mlen[3];
  endfunction

  task automatic step(input bit req, input bit av, input int aid, input string tag);
    bit ev;
    int ec;
    int g;
    int gp;
    ev = 0; ec = 0; g = -1; gp = 0;
    serv_req  = req;
    arr_valid = av;
    arr_conn  = 4'(aid);
    if (req) begin
      for (int p = 3; p >= 0; p--)
        if (g < 0 && mlen[p] > 0) begin g = mq[p][0]; gp = p; end
      if (g >= 0) begin
        ev = 1; ec = g;
        mpop(gp);
        mcnt[g]--;
        if (av && aid == g) mcnt[g]++;
        if (mcnt[g] > 0) mpush(gp, g);
        else minq[g] = 0;
      end
    end
    if (av && aid != g) begin
      if (!minq[aid]) begin mpush(cp(aid), aid); minq[aid] = 1; end
      mcnt[aid]++;
    end
    @(posedge clk);
    @(negedge clk);
    serv_req  = 1'b0;
    arr_valid = 1'b0;
    checks++;
    if (gnt_valid !== ev || (ev && gnt_conn !== 4'(ec))) begin
      failures++;
      $display("FAIL %s: grant valid=%0b conn=%0d, expected valid=%0b conn=%0d",
               tag, gnt_valid, gnt_conn, ev, ec);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NC; c++) conn_prio[2*c +: 2] = 2'(cp(c));
    for (int p = 0; p < 4; p++) mlen[p] = 0;
    for (int c = 0; c < NC; c++) begin mcnt[c] = 0; minq[c] = 0; end
    rst = 1'b1; arr_valid = 1'b0; arr_conn = '0; serv_req = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (gnt_valid !== 1'b0) begin
      failures++;
      $display("FAIL R9: gnt_valid=%0b during reset, expected 0", gnt_valid);
    end
    rst = 1'b0;
    // R9: request on an empty scheduler yields nothing
    step(1, 0, 0, "R9");
    // Level 1 holds 1 and 4; level 0 holds 0; level 3 holds 3, 6
    step(0, 1, 1, "R3");
    step(0, 1, 4, "R3");
    step(0, 1, 1, "R10");          // 1 already linked: order stays 1,4
    step(0, 1, 0, "R3");
    step(1, 1, 3, "R1");           // 3 arrives while 1 is served
    step(1, 0, 0, "R1");           // level 3 wins: grant 3
    step(1, 0, 0, "R4");           // 4 (1 re-entered behind it)
    step(1, 0, 0, "R4");           // 1 again, last cell
    step(1, 0, 0, "R1");           // level 0: connection 0
    step(1, 0, 0, "R5");           // nothing left
    // R6: arrival on the connection being served keeps it linked
    step(0, 1, 2, "R6");
    step(1, 1, 2, "R6");
    step(1, 0, 0, "R6");
    step(1, 0, 0, "R5");
    // R8: re-entry of 1 and newcomer 4 on the same level in one cycle
    step(0, 1, 1, "R8");
    step(0, 1, 1, "R8");
    step(1, 1, 4, "R8");
    step(1, 0, 0, "R8");
    step(1, 0, 0, "R8");
    step(1, 0, 0, "R5");
    // Strict priority with several levels busy
    step(0, 1, 6, "R1");
    step(0, 1, 5, "R1");
    step(0, 1, 7, "R1");
    step(1, 1, 3, "R1");
    step(1, 0, 0, "R4");
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R5");
    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bit rq;
      bit av;
      int id;
      rq = ($urandom % 4) != 0;
      av = ($urandom % 3) != 0;
      id = $urandom % NC;
      if (mcnt[id] >= 200) av = 0;
      step(rq, av, id, "R7");
    end
    // Drain: every cell must be granted exactly once (R7)
    for (int i = 0; i < 5000 && mtotal() > 0; i++) step(1, 0, 0, "R7");
    step(1, 0, 0, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule